// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder

This block is the device-side control of a by-one dynamic memory, modelled as synchronous logic. A fast clock samples the active-low row strobe, column strobe and write enable. The block sorts each row-strobe period into one of three cycle types: an ordinary access, a refresh of an externally given row, or a refresh driven by the internal row counter because the column strobe was already low. From that it produces the internal row and column addresses, the read data and the output enable. A small behavioural array stands in for the cell matrix.

A refresh that uses the internal counter and has write enable low switches the block into a compressed test mode. In that mode the array is seen as words of 16 bits. A write fills a whole word with the data bit. A read reports on the data output whether all 16 bits of the word agree. An internal-counter refresh with write enable high, or a refresh of an external row, returns the block to normal operation. If the column strobe is held low after a read while the row strobe cycles, the block does a hidden refresh and keeps the read data on the output.

Top module: `strobe_cycle_decoder`

## Requirements
- R1: After reset, q_oe_o is 0, test_mode_o is 0, cyc_o is 0 (idle), row_o is 0 and the refresh counter holds 0.
- R2: A row-strobe fall with cas_ni already low is a counter refresh. cyc_o becomes 3, row_o takes the counter value with addr_i ignored, and the counter then advances by one.
- R3: The refresh counter is 12 bits wide and wraps from 4095 to 0.
- R4: If cas_ni stays high for the whole row-strobe low period, cyc_o becomes 2 on the row-strobe rise, row_o holds the addr_i value taken at the row-strobe fall, and q_oe_o stays 0.
- R5: A row-strobe fall with cas_ni high starts an access. cyc_o becomes 1 and row_o takes addr_i. A read returns the last bit written to the same cell. A cell is selected by row bits [1:0] and column bits [3:2], [11:10] and [1:0]; the other address bits alias.
- R6: During an access, col_o follows addr_i while cas_ni is high. It holds the value captured at the column-strobe fall while cas_ni is low.
- R7: q_oe_o rises in the clock after a column-strobe fall with we_ni high in an access, and falls in the clock after the column-strobe rise.
- R8: A column-strobe fall with we_ni low is an early write: d_i is stored and q_oe_o stays 0. A we_ni fall while the column strobe is low in an access is a late write: it stores d_i at the captured column.
- R9: A counter refresh with we_ni low sets test_mode_o and still refreshes (R2 behaviour).
- R10: test_mode_o is cleared by a counter refresh with we_ni high or by a refresh of an external row (R4).
- R11: In test mode, column bits [11:10] and [1:0] are ignored and a write stores d_i into all 16 bits of the addressed word.
- R12: A test-mode read drives q_o to 1 when all 16 bits of the word are equal and to 0 when any bit differs.
- R13: While cas_ni stays low after a read, row-strobe cycling performs counter refreshes (R2) with q_oe_o held at 1 and q_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | ADDR_W | Multiplexed row/column address |
| d_i | input | 1 | Write data bit |
| q_o | output | 1 | Read data or test-mode compare result |
| q_oe_o | output | 1 | Output enable for q_o |
| row_o | output | ADDR_W | Internal row address of the current cycle |
| col_o | output | ADDR_W | Internal column address |
| cyc_o | output | 2 | Cycle type: 0 idle, 1 access, 2 external-row refresh, 3 counter refresh |
| test_mode_o | output | 1 | Compressed test mode active |

## Verification
Ordinary reads and writes use random 12-bit rows and columns against an aliasing model of the array. This shows that the cell selection keeps only the stated bits and that early and late writes both land in the right cell. Strobe orders are applied directly, so the cycle types can be told apart: column strobe before row strobe with write enable high or low, column strobe never falling, and column strobe held across a new row cycle. Test mode is run with a uniform word and then with one bit flipped through a normal write, which separates the compare's pass and fail results. A long run of counter refreshes reaches the counter wrap.

// File: rtl/dram_cyc_pkg.sv
package dram_cyc_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE     = 2'd0,
    CYC_ACCESS   = 2'd1,
    CYC_RAS_ONLY = 2'd2,
    CYC_CBR      = 2'd3
  } cyc_e;

  localparam int unsigned SEL_W = 4;
  localparam int unsigned GRP_W = 1 << SEL_W;
endpackage

// File: rtl/strobe_sampler.sv
module strobe_sampler #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] prev_o
);
  // strobes idle high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_o <= '1;
    else         prev_o <= sig_i;
  end
endmodule

// File: rtl/refresh_ctr.sv
module refresh_ctr #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/cell_array.sv
module cell_array #(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned SEL_W = 4,
  localparam int unsigned GRP_W = 1 << SEL_W,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             wr_en_i,
  input  logic             wr_all_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic             wr_bit_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [GRP_W-1:0] rd_word_o
);
  logic [GRP_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk_i) begin
      if (wr_en_i && wr_idx_i == IDX_W'(g)) begin
        if (wr_all_i) mem_q[g] <= {GRP_W{wr_bit_i}};
        else          mem_q[g][wr_sel_i] <= wr_bit_i;
      end
    end
  end

  assign rd_word_o = mem_q[rd_idx_i];
endmodule

// File: rtl/strobe_cycle_decoder.sv
module strobe_cycle_decoder
  import dram_cyc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned ROW_KEEP = 2,
  parameter int unsigned COL_KEEP = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              d_i,
  output logic              q_o,
  output logic              q_oe_o,
  output logic [ADDR_W-1:0] row_o,
  output logic [ADDR_W-1:0] col_o,
  output logic [1:0]        cyc_o,
  output logic              test_mode_o
);
  localparam int unsigned IDX_W = ROW_KEEP + COL_KEEP;

  logic [2:0]        prev;
  logic              ras_fall, ras_rise, cas_fall, cas_rise, we_fall;
  logic [ADDR_W-1:0] cnt;
  logic              in_acc_q, cas_seen_q, test_q, q_oe_q, q_q;
  logic [ADDR_W-1:0] row_q, col_q;
  cyc_e              cyc_q;
  logic              acc_cas_fall, late_we, wr_en;
  logic [ADDR_W-1:0] wr_col;
  logic [IDX_W-1:0]  rd_idx, wr_idx;
  logic [SEL_W-1:0]  rd_sel, wr_sel;
  logic [GRP_W-1:0]  rd_word;
  logic              rd_bit;

  strobe_sampler #(.N(3)) i_sampler (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  ({we_ni, cas_ni, ras_ni}),
    .prev_o (prev)
  );

  assign ras_fall = prev[0] & ~ras_ni;
  assign ras_rise = ~prev[0] & ras_ni;
  assign cas_fall = prev[1] & ~cas_ni;
  assign cas_rise = ~prev[1] & cas_ni;
  assign we_fall  = prev[2] & ~we_ni;

  refresh_ctr #(.W(ADDR_W)) i_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (ras_fall & ~cas_ni),
    .cnt_o  (cnt)
  );

  assign acc_cas_fall = in_acc_q & ~ras_ni & cas_fall;
  assign late_we      = in_acc_q & ~ras_ni & ~cas_ni & ~cas_fall & we_fall;
  assign wr_en        = (acc_cas_fall & ~we_ni) | late_we;
  assign wr_col       = acc_cas_fall ? addr_i : col_q;

  // cell key drops the four test-compressed column bits into the word select
  assign rd_idx = {row_q[ROW_KEEP-1:0], addr_i[2 +: COL_KEEP]};
  assign wr_idx = {row_q[ROW_KEEP-1:0], wr_col[2 +: COL_KEEP]};
  assign rd_sel = {addr_i[ADDR_W-1], addr_i[ADDR_W-2], addr_i[1], addr_i[0]};
  assign wr_sel = {wr_col[ADDR_W-1], wr_col[ADDR_W-2], wr_col[1], wr_col[0]};

  cell_array #(.IDX_W(IDX_W), .SEL_W(SEL_W)) i_array (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en),
    .wr_all_i  (test_q),
    .wr_idx_i  (wr_idx),
    .wr_sel_i  (wr_sel),
    .wr_bit_i  (d_i),
    .rd_idx_i  (rd_idx),
    .rd_word_o (rd_word)
  );

  assign rd_bit = test_q ? ((&rd_word) | ~(|rd_word)) : rd_word[rd_sel];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_acc_q   <= 1'b0;
      cas_seen_q <= 1'b0;
      test_q     <= 1'b0;
      q_oe_q     <= 1'b0;
      q_q        <= 1'b0;
      row_q      <= '0;
      col_q      <= '0;
      cyc_q      <= CYC_IDLE;
    end else begin
      if (ras_fall) begin
        if (!cas_ni) begin
          row_q    <= cnt;
          test_q   <= ~we_ni;
          cyc_q    <= CYC_CBR;
          in_acc_q <= 1'b0;
        end else begin
          row_q      <= addr_i;
          in_acc_q   <= 1'b1;
          cas_seen_q <= 1'b0;
          cyc_q      <= CYC_ACCESS;
        end
      end else if (ras_rise && in_acc_q) begin
        in_acc_q <= 1'b0;
        if (!cas_seen_q) begin
          cyc_q  <= CYC_RAS_ONLY;
          test_q <= 1'b0;
        end
      end
      if (acc_cas_fall) begin
        col_q      <= addr_i;
        cas_seen_q <= 1'b1;
        q_oe_q     <= we_ni;
        if (we_ni) q_q <= rd_bit;
      end else if (cas_rise) begin
        q_oe_q <= 1'b0;
      end
    end
  end

  assign col_o       = (in_acc_q && cas_ni) ? addr_i : col_q;
  assign row_o       = row_q;
  assign q_o         = q_q;
  assign q_oe_o      = q_oe_q;
  assign cyc_o       = cyc_q;
  assign test_mode_o = test_q;
endmodule

// File: rtl/strobe_cycle_checker.sv
module strobe_cycle_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic ras_ni,
  input logic cas_ni,
  input logic we_ni,
  input logic q_o,
  input logic q_oe_o,
  input logic test_mode_o
);
  // R7
  oe_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(q_oe_o) |-> (!$past(cas_ni) && $past(we_ni) && !$past(ras_ni)));

  // R7
  oe_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cas_ni) |=> !q_oe_o);

  // R4
  oe_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cas_ni |=> !q_oe_o);

  // R8
  early_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cas_ni) && !we_ni) |=> !q_oe_o);

  // R9
  tm_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_ni) && !cas_ni && !we_ni) |=> test_mode_o);

  // R10
  tm_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_ni) && !cas_ni && we_ni) |=> !test_mode_o);

  // R13
  hidden_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_oe_o && !cas_ni) |=> (q_oe_o && $stable(q_o)));
endmodule

bind strobe_cycle_decoder strobe_cycle_checker i_chk (.*);

// File: tb/test_strobe_cycle_decoder.sv
`timescale 1ns/1ps
module test_strobe_cycle_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, din = 1'b0;
  logic [11:0] addr = '0;
  logic q, q_oe, tm;
  logic [11:0] row, col;
  logic [1:0] cyc;

  int n_tests = 0, n_fail = 0;
  logic [11:0] ref_cnt = '0;
  bit ref_tm = 1'b0;
  logic [15:0] mdl [16];

  always #2.5 clk = ~clk;

  strobe_cycle_decoder i_strobe_cycle_decoder (
    .clk_i(clk), .rst_ni(rst_n), .ras_ni(ras_n), .cas_ni(cas_n), .we_ni(we_n),
    .addr_i(addr), .d_i(din), .q_o(q), .q_oe_o(q_oe), .row_o(row), .col_o(col),
    .cyc_o(cyc), .test_mode_o(tm)
  );

  function automatic int f_idx(logic [11:0] r, logic [11:0] c);
    return int'({r[1:0], c[3:2]});
  endfunction
  function automatic int f_sel(logic [11:0] c);
    return int'({c[11], c[10], c[1], c[0]});
  endfunction
  function automatic bit f_read(logic [11:0] r, logic [11:0] c);
    logic [15:0] w = mdl[f_idx(r, c)];
    if (ref_tm) return (w == 16'h0000) || (w == 16'hFFFF);
    return w[f_sel(c)];
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  task automatic do_read(logic [11:0] r, logic [11:0] c, string tag);
    bit exp = f_read(r, c);
    ras_n = 1'b0; addr = r; step();
    chk("R5 access row", int'(row), int'(r));
    chk("R5 access type", int'(cyc), 1);
    addr = c; step();
    cas_n = 1'b0; step();
    chk("R7 read enable", int'(q_oe), 1);
    chk(tag, int'(q), int'(exp));
    cas_n = 1'b1; step();
    chk("R7 enable drop", int'(q_oe), 0);
    ras_n = 1'b1; step();
  endtask

  task automatic do_write(logic [11:0] r, logic [11:0] c, bit d, bit early);
    ras_n = 1'b0; addr = r; step();
    addr = c; din = d;
    if (early) we_n = 1'b0;
    step();
    cas_n = 1'b0; step();
    if (early) chk("R8 early write keeps output off", int'(q_oe), 0);
    else begin
      we_n = 1'b0; step();
    end
    cas_n = 1'b1; step();
    we_n = 1'b1; ras_n = 1'b1; step();
    if (ref_tm) mdl[f_idx(r, c)] = {16{d}};
    else mdl[f_idx(r, c)][f_sel(c)] = d;
  endtask

  task automatic do_cbr(bit w, bit check);
    cas_n = 1'b0; we_n = w; step();
    ras_n = 1'b0; addr = 12'($urandom); step();
    if (check) begin
      chk("R2 counter row, address ignored", int'(row), int'(ref_cnt));
      chk("R2 counter refresh type", int'(cyc), 3);
      chk(w ? "R10 exit by counter refresh" : "R9 test mode entry", int'(tm), int'(!w));
    end
    ref_cnt++;
    ref_tm = !w;
    ras_n = 1'b1; step();
    cas_n = 1'b1; we_n = 1'b1; step();
  endtask

  task automatic do_ror(logic [11:0] r);
    ras_n = 1'b0; addr = r; step();
    chk("R4 external row", int'(row), int'(r));
    step();
    ras_n = 1'b1; step();
    chk("R4 refresh type", int'(cyc), 2);
    chk("R4 output off", int'(q_oe), 0);
    chk("R10 exit by external-row refresh", int'(tm), 0);
    ref_tm = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [11:0] r, c;
    bit rq;
    void'($urandom(32'd2024));
    repeat (3) step();
    chk("R1 reset output enable", int'(q_oe), 0);
    chk("R1 reset test mode", int'(tm), 0);
    chk("R1 reset cycle type", int'(cyc), 0);
    chk("R1 reset row", int'(row), 0);
    rst_n = 1'b1; step();

    // test mode clears every word (R11), first refresh row is 0 (R1)
    do_cbr(1'b0, 1'b1);
    for (int i = 0; i < 16; i++) do_write(12'(i >> 2), 12'((i & 3) << 2), 1'b0, 1'b1);
    do_read(12'h001, 12'h004, "R12 uniform word reads pass");
    do_cbr(1'b1, 1'b1);

    // R6 column transparency and capture
    ras_n = 1'b0; addr = 12'h123; step();
    addr = 12'h0A5; #1 chk("R6 transparent column", int'(col), 12'h0A5);
    addr = 12'h35A; #1 chk("R6 transparent column follows", int'(col), 12'h35A);
    cas_n = 1'b0; step();
    addr = 12'hFFF; #1 chk("R6 captured column", int'(col), 12'h35A);
    cas_n = 1'b1; step(); ras_n = 1'b1; step();

    // R5 / R8 directed writes
    do_write(12'h005, 12'h00C, 1'b1, 1'b1);
    do_read(12'h005, 12'h00C, "R5 early write readback");
    do_read(12'h005, 12'h00D, "R5 neighbour cell untouched");
    do_write(12'h7F6, 12'hC08, 1'b1, 1'b0);
    do_read(12'h002, 12'hC08, "R8 late write readback via alias row");

    // random normal traffic
    for (int k = 0; k < 60; k++) begin
      r = 12'($urandom); c = 12'($urandom);
      if ($urandom % 2 == 0) do_write(r, c, 1'($urandom), 1'($urandom));
      else do_read(r, c, "R5 random readback");
    end

    // R11 / R12 test-mode word behaviour
    r = 12'h2A1; c = 12'h0F4;
    do_cbr(1'b0, 1'b1);
    do_write(r, c, 1'b1, 1'b0);
    do_read(r, c, "R12 all ones word passes");
    do_cbr(1'b1, 1'b1);
    do_read(r, c ^ 12'h001, "R11 word bit set by test write");
    do_read(r, c ^ 12'hC03, "R11 word bit set by test write");
    do_write(r, c | 12'h800, 1'b0, 1'b1);
    do_cbr(1'b0, 1'b1);
    do_read(r, c, "R12 mismatching word fails");
    do_ror(12'h9C3);

    // R13 hidden refresh
    r = 12'h005; c = 12'h00C;
    rq = f_read(r, c);
    ras_n = 1'b0; addr = r; step();
    addr = c; step();
    cas_n = 1'b0; step();
    chk("R13 read before hidden refresh", int'(q), int'(rq));
    ras_n = 1'b1; step();
    ras_n = 1'b0; addr = 12'hABC; step();
    chk("R13 hidden refresh row", int'(row), int'(ref_cnt));
    chk("R13 output held", int'(q_oe), 1);
    chk("R13 data held", int'(q), int'(rq));
    ref_cnt++;
    ras_n = 1'b1; step();
    cas_n = 1'b1; step();
    chk("R7 enable drop after hidden refresh", int'(q_oe), 0);

    // R3 counter wrap
    while (ref_cnt != 12'hFFF) do_cbr(1'b1, 1'b0);
    do_cbr(1'b1, 1'b1);
    chk("R3 counter wrapped", int'(ref_cnt), 0);
    do_cbr(1'b1, 1'b1);

    summary();
    $finish;
  end
endmodule